// File: doc/BRIEF.md
# Three-Wire Bus Grant Requester

This block lets a DMA engine become bus master on a system bus that hands over mastership through three signals: a request from the would-be master, a grant from the current owner, and an acknowledge that the new master asserts once it has actually taken the bus. The engine raises a trigger when its FIFO reaches its threshold or when it must touch a descriptor area. The block then pulls the active-low request line down and waits for the grant. A grant alone is not enough to take the bus. The block also waits until the previous master has dropped its acknowledge, the address strobe is inactive, both data-size acknowledge lines are released and, in asynchronous mode only, the synchronous-termination line is released.

Once the block has asserted its own acknowledge it keeps the bus until the engine signals the end of its block transfer or a switch to another memory area. Removing the grant has no effect while the block holds the bus. On release, the acknowledge stays low for one holding cycle after the last DMA cycle, so the next master cannot contend with it. After an area switch the block goes back through idle and requests the bus again.

The grant, previous-acknowledge, strobe and termination inputs pass through a synchroniser before use. All bus handshake lines are active-low and are released while reset is held.

Top module: `bus_grant_requester`

## Requirements
- R1: During and directly after a synchronous reset, br_n = 1, bgack_n = 1 and dma_go = 0.
- R2: From idle, a high level on fifo_req or desc_req drives br_n low on the first clock edge that samples it. Neither trigger may assert bgack_n.
- R3: While the previous master's acknowledge bgack_in_n is low (active), the block does not assert bgack_n, even with the grant bg_n held low.
- R4: While the address strobe as_n is low, the block does not assert bgack_n.
- R5: While either bit of dsack_n is low, the block does not assert bgack_n.
- R6: With async_mode = 1, a low sterm_n blocks the claim. With async_mode = 0, sterm_n has no effect on the claim.
- R7: With the grant low and every blocking line inactive, bgack_n goes low, br_n returns high and dma_go goes high. This happens exactly SYNC_STAGES+1 clock edges after the last blocking input was released. br_n and bgack_n are never low together.
- R8: While the block owns the bus, raising bg_n (an attempted preemption) or activating any of the other bus lines leaves bgack_n low and dma_go high.
- R9: A blk_done pulse during ownership drops dma_go on the next edge while bgack_n stays low. bgack_n then returns high exactly one edge later (the holding cycle).
- R10: An area_switch pulse releases the bus with the same holding cycle as R9. If a trigger is still high, br_n falls again one edge after bgack_n returns high.
- R11: A low bg_n with no pending request produces no claim. bgack_n and br_n stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_req | input | 1 | Engine trigger: FIFO threshold reached |
| desc_req | input | 1 | Engine trigger: descriptor area access needed |
| blk_done | input | 1 | Pulse: last DMA cycle of the block transfer finished |
| area_switch | input | 1 | Pulse: engine moves to another memory area |
| async_mode | input | 1 | 1 = synchronous-termination line is part of the idle check |
| bg_n | input | 1 | Bus grant, active low |
| bgack_in_n | input | 1 | Previous master's grant acknowledge, active low |
| as_n | input | 1 | Address strobe, active low |
| dsack_n | input | DSACK_W | Data-size acknowledge lines, active low |
| sterm_n | input | 1 | Synchronous termination, active low |
| br_n | output | 1 | Bus request, active low |
| bgack_n | output | 1 | Own grant acknowledge, active low |
| dma_go | output | 1 | Engine may run bus cycles |

## Verification
The bench sweeps every combination of the five blocking lines against both async_mode settings. Each combination checks whether a claim happens, so a design that drops one line from the idle check, or that gates on sterm_n in the wrong mode, is caught. Where the claim is blocked, the bench releases all lines and counts edges until the acknowledge falls. A design with a missing or extra synchroniser stage, or an unregistered claim, gives the wrong count. Each claimed bus is then hit with a grant removal and must survive it; a preemptible design lets go here. The release is checked edge by edge: a design without the holding cycle, or with a longer one, shows the acknowledge rising at the wrong edge. The area-switch path must also request the bus again on its own.

// File: rtl/bgr_pkg.sv
package bgr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_OWN  = 2'd2,
    ST_HOLD = 2'd3
  } bgr_state_e;
endpackage

// File: rtl/bgr_sync.sv
module bgr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) pipe[0] <= INIT;
    else     pipe[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) pipe[i] <= INIT;
      else     pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/bgr_idle_check.sv
module bgr_idle_check #(
  parameter int DSACK_W = 2
) (
  input  logic               prev_ack_n,
  input  logic               strobe_n,
  input  logic [DSACK_W-1:0] size_ack_n,
  input  logic               term_n,
  input  logic               async_mode,
  output logic               bus_free
);
  // A line counts as released when it sits high; termination only matters in async mode.
  always_comb begin
    bus_free = prev_ack_n & strobe_n & (&size_ack_n) & (term_n | ~async_mode);
  end
endmodule

// File: rtl/bus_grant_requester.sv
module bus_grant_requester
  import bgr_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int DSACK_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fifo_req,
  input  logic               desc_req,
  input  logic               blk_done,
  input  logic               area_switch,
  input  logic               async_mode,
  input  logic               bg_n,
  input  logic               bgack_in_n,
  input  logic               as_n,
  input  logic [DSACK_W-1:0] dsack_n,
  input  logic               sterm_n,
  output logic               br_n,
  output logic               bgack_n,
  output logic               dma_go
);
  localparam int SW = DSACK_W + 4;

  logic [SW-1:0] raw_lines, sync_lines;
  logic          bg_s, prev_ack_s, strobe_s, term_s;
  logic [DSACK_W-1:0] size_ack_s;
  logic          bus_free;
  bgr_state_e    state_q, state_d;

  assign raw_lines = {bg_n, bgack_in_n, as_n, sterm_n, dsack_n};

  bgr_sync #(.W(SW), .STAGES(SYNC_STAGES), .INIT({SW{1'b1}})) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw_lines),
    .q   (sync_lines)
  );

  assign bg_s       = sync_lines[SW-1];
  assign prev_ack_s = sync_lines[SW-2];
  assign strobe_s   = sync_lines[SW-3];
  assign term_s     = sync_lines[SW-4];
  assign size_ack_s = sync_lines[DSACK_W-1:0];

  bgr_idle_check #(.DSACK_W(DSACK_W)) u_idle (
    .prev_ack_n (prev_ack_s),
    .strobe_n   (strobe_s),
    .size_ack_n (size_ack_s),
    .term_n     (term_s),
    .async_mode (async_mode),
    .bus_free   (bus_free)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (fifo_req || desc_req)     state_d = ST_REQ;
      ST_REQ:  if (!bg_s && bus_free)        state_d = ST_OWN;
      ST_OWN:  if (blk_done || area_switch)  state_d = ST_HOLD;
      ST_HOLD:                               state_d = ST_IDLE;
      default:                               state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      br_n    <= 1'b1;
      bgack_n <= 1'b1;
      dma_go  <= 1'b0;
    end else begin
      state_q <= state_d;
      br_n    <= (state_d != ST_REQ);
      bgack_n <= !(state_d == ST_OWN || state_d == ST_HOLD);
      dma_go  <= (state_d == ST_OWN);
    end
  end
endmodule

// File: rtl/bgr_checker.sv
module bgr_checker (
  input logic clk,
  input logic rst,
  input logic blk_done,
  input logic area_switch,
  input logic br_n,
  input logic bgack_n,
  input logic dma_go
);
  a_r1_reset_release: assert property (@(posedge clk) rst |=> (br_n && bgack_n && !dma_go));

  a_r7_no_double_low: assert property (@(posedge clk) disable iff (rst) !(!br_n && !bgack_n));

  a_r7_claim_after_req: assert property (@(posedge clk) disable iff (rst)
    $fell(bgack_n) |-> ($past(br_n) == 1'b0 && dma_go));

  a_r8_no_preempt: assert property (@(posedge clk) disable iff (rst)
    (dma_go && !blk_done && !area_switch) |=> (dma_go && !bgack_n));

  a_r9_hold_cycle: assert property (@(posedge clk) disable iff (rst)
    (dma_go && (blk_done || area_switch)) |=> (!dma_go && !bgack_n));

  a_r9_hold_ends: assert property (@(posedge clk) disable iff (rst)
    (!bgack_n && !dma_go) |=> bgack_n);
endmodule

bind bus_grant_requester bgr_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .blk_done    (blk_done),
  .area_switch (area_switch),
  .br_n        (br_n),
  .bgack_n     (bgack_n),
  .dma_go      (dma_go)
);

// File: tb/bus_grant_requester_tb.sv
module bus_grant_requester_tb;
  localparam int SYNC_STAGES = 2;
  localparam int DSACK_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_req = 0, desc_req = 0, blk_done = 0, area_switch = 0, async_mode = 0;
  logic bg_n = 1, bgack_in_n = 1, as_n = 1, sterm_n = 1;
  logic [DSACK_W-1:0] dsack_n = '1;
  logic br_n, bgack_n, dma_go;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  bus_grant_requester #(.SYNC_STAGES(SYNC_STAGES), .DSACK_W(DSACK_W)) u_dut (
    .clk (clk), .rst (rst), .fifo_req (fifo_req), .desc_req (desc_req),
    .blk_done (blk_done), .area_switch (area_switch), .async_mode (async_mode),
    .bg_n (bg_n), .bgack_in_n (bgack_in_n), .as_n (as_n), .dsack_n (dsack_n),
    .sterm_n (sterm_n), .br_n (br_n), .bgack_n (bgack_n), .dma_go (dma_go)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic lines_free();
    bgack_in_n = 1; as_n = 1; dsack_n = '1; sterm_n = 1;
  endtask

  // Releases an owned bus with blk_done and checks the holding cycle (R9).
  task automatic finish_block();
    blk_done = 1;
    step(1);
    blk_done = 0;
    chk(dma_go == 0 && bgack_n == 0, "R9 hold cycle", {dma_go, bgack_n}, 0);
    step(1);
    chk(bgack_n == 1, "R9 release after hold", bgack_n, 1);
  endtask

  initial begin
    step(3);
    chk(br_n == 1 && bgack_n == 1 && dma_go == 0, "R1 in reset", {br_n, bgack_n, dma_go}, 6);
    rst = 0;
    step(1);
    chk(br_n == 1 && bgack_n == 1 && dma_go == 0, "R1 after reset", {br_n, bgack_n, dma_go}, 6);

    // R11: grant without request
    bg_n = 0;
    step(6);
    chk(bgack_n == 1 && br_n == 1, "R11 grant ignored", {br_n, bgack_n}, 3);
    bg_n = 1;
    step(3);

    // R2: descriptor trigger
    desc_req = 1;
    step(1);
    chk(br_n == 0, "R2 desc trigger", br_n, 0);
    chk(bgack_n == 1, "R2 no claim without grant", bgack_n, 1);
    desc_req = 0;
    bg_n = 0;
    step(SYNC_STAGES + 1);
    chk(bgack_n == 0 && br_n == 1 && dma_go == 1, "R7 claim", {br_n, bgack_n, dma_go}, 5);
    finish_block();
    bg_n = 1;
    step(3);

    // Sweep over the blocking lines and both modes (R3..R8)
    for (int m = 0; m < 2; m++) begin
      for (int c = 0; c < 32; c++) begin
        automatic logic [4:0] v = c[4:0];
        automatic bit free = v[0] & v[1] & v[2] & v[3] & (v[4] | (m == 0));
        automatic int k = 0;
        async_mode = m[0];
        bgack_in_n = v[0]; as_n = v[1]; dsack_n = v[3:2]; sterm_n = v[4];
        fifo_req = 1;
        bg_n = 0;
        step(8);
        if (!v[0]) chk(bgack_n == 1, "R3 prev ack blocks", bgack_n, 1);
        if (!v[1]) chk(bgack_n == 1, "R4 strobe blocks", bgack_n, 1);
        if (!v[2] || !v[3]) chk(bgack_n == 1, "R5 size ack blocks", bgack_n, 1);
        if (!v[4]) chk(bgack_n == (free ? 0 : 1), "R6 termination mode", bgack_n, free ? 0 : 1);
        chk(bgack_n == !free && br_n == free, "R7 claim decision", {br_n, bgack_n}, free ? 2 : 1);
        if (!free) begin
          lines_free();
          for (int t = 1; t <= 8 && k == 0; t++) begin
            step(1);
            if (bgack_n == 0) k = t;
          end
          chk(k == SYNC_STAGES + 1, "R7 claim latency", k, SYNC_STAGES + 1);
        end
        fifo_req = 0;
        bg_n = 1;
        bgack_in_n = 0; as_n = 0; dsack_n = '0; sterm_n = 0;
        step(5);
        chk(bgack_n == 0 && dma_go == 1, "R8 no preemption", {bgack_n, dma_go}, 1);
        lines_free();
        finish_block();
        chk(br_n == 1, "R9 no new request", br_n, 1);
        step(2);
      end
    end

    // R10: area switch with the trigger still high
    async_mode = 0;
    fifo_req = 1;
    bg_n = 0;
    step(SYNC_STAGES + 3);
    chk(bgack_n == 0, "R10 owned before switch", bgack_n, 0);
    area_switch = 1;
    step(1);
    area_switch = 0;
    chk(dma_go == 0 && bgack_n == 0, "R10 hold cycle", {dma_go, bgack_n}, 0);
    step(1);
    chk(bgack_n == 1 && br_n == 1, "R10 released", {br_n, bgack_n}, 3);
    step(1);
    chk(br_n == 0, "R10 request again", br_n, 0);
    fifo_req = 0;
    step(2);
    chk(bgack_n == 0, "R10 reclaimed", bgack_n, 0);
    finish_block();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule